// File: doc/BRIEF.md
# Slow-Clock Counter with Match Interrupt

This block keeps a 32-bit count that runs from a slow timekeeping clock, nominally 32.768 kHz. A much faster bus clock controls it through five word registers. Software turns counting on, sets a prescale value, loads a starting count, reads the live count back and programs a match value. Every write that targets the slow domain crosses with a toggle handshake. Each of the three crossing registers reports a busy flag until its value has been taken up on the slow side. A write aimed at a register that is still busy is dropped, and a sticky error flag records it.

A typical use is a one-shot timer. Software reads the count, adds a delay of at least nine ticks, writes the sum as the match value and waits for the interrupt. The interrupt is a level. It stays up until software clears it through the control word, or until a new match value is accepted. A sticky status bit shows that slow-clock edges have arrived. Software checks this bit together with the enable bit before it relies on the counter.

Register map (3-bit word address): 0 control/status, 1 prescale, 2 count load, 3 count read (read only; writes are dropped without error), 4 match.
Control/status bits:
- Read: bit 0 enable, bit 1 slow clock seen, bit 2 prescale busy, bit 3 load busy, bit 4 match busy, bit 5 write error, bit 6 interrupt pending.
- Write: bit 0 sets enable, a 1 in bit 5 clears the error flag, a 1 in bit 7 clears the interrupt.

Top module: `slow_cnt_match`

## Requirements
- R1: After reset, every register reads 0, including all status bits and the count, and irq_o is low.
- R2: Status bit 1 reads 1 once the bus side has seen a slow-clock edge, and it stays 1 while the slow clock is stopped.
- R3: While control bit 0 is 0 the count holds its value. With bit 0 set it advances, starting at the third slow edge after the control write.
- R4: With a prescale value of N, the count advances once every N+1 slow edges. The prescale phase restarts at 0 whenever a load takes effect, so N=0 advances the count on every edge.
- R5: An accepted count-load write sets status bit 3 at once. The new value replaces the count on the third slow edge after the write, and bit 3 clears a few bus cycles after that edge.
- R6: Accepted prescale and match writes behave the same way, using status bit 2 and status bit 4.
- R7: A write to the prescale, load or match register while that register's busy bit is set changes nothing: the register read-back keeps the earlier value. The write sets status bit 5, and a control write with bit 5 set clears it.
- R8: The count wraps from 0xFFFFFFFF to 0.
- R9: When the count reaches the match value, irq_o rises, and status bit 6 reads 1, within a few bus cycles of that slow edge.
- R10: The interrupt drops on the cycle after a control write with bit 7 set, or after an accepted match write.
- R11: A match value written nine ticks ahead of the current count raises irq_o on exactly the ninth slow edge, and not before it.
- R12: The count read-back shows the value after a slow edge within four bus cycles of that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| slow_clk_i | input | 1 | Slow count clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | 1 | Match interrupt level |

## Verification
The bench drives the slow clock one edge at a time. This makes every crossing latency exact, so the checks can name the slow edge on which a load, prescale or match write lands. A design that applied writes one edge early or late would return the wrong count after a load, and it would raise the interrupt on the wrong tick of a nine-tick lead. A back-to-back write pair checks that the second write is dropped and flagged, rather than silently replacing data that is still crossing. The bench also checks a wrap through zero under prescale and a stopped slow clock, which together catch a non-sticky clock-seen bit and a prescale phase that is not reset by a load.

// File: rtl/scm_pkg.sv
package scm_pkg;
  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_TRIM  = 3'd1,
    A_LOAD  = 3'd2,
    A_COUNT = 3'd3,
    A_MATCH = 3'd4
  } reg_addr_e;

  localparam int unsigned ADDR_W      = 3;
  localparam int unsigned B_EN        = 0;
  localparam int unsigned B_SEEN      = 1;
  localparam int unsigned B_TRIM_BUSY = 2;
  localparam int unsigned B_LOAD_BUSY = 3;
  localparam int unsigned B_MTCH_BUSY = 4;
  localparam int unsigned B_ERR       = 5;
  localparam int unsigned B_IRQ       = 6;
  localparam int unsigned B_IRQ_CLR   = 7;
endpackage

// File: rtl/scm_bit_sync.sv
module scm_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/scm_wr_chan.sv
// Toggle handshake carrying one register write from the bus domain to the slow domain.
module scm_wr_chan #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         bclk_i,
  input  logic         sclk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         busy_o,
  output logic [W-1:0] hold_o,
  output logic         apply_o
);
  logic req_q, ack_b, req_s, seen_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      hold_q <= '0;
    end else if (wr_i) begin
      req_q  <= ~req_q;
      hold_q <= wdata_i;
    end
  end

  scm_bit_sync #(.STAGES(STAGES)) u_req_sync (
    .clk_i(sclk_i), .rst_ni(rst_ni), .d_i(req_q), .q_o(req_s)
  );

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= req_s;
  end

  scm_bit_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk_i(bclk_i), .rst_ni(rst_ni), .d_i(seen_q), .q_o(ack_b)
  );

  assign apply_o = req_s ^ seen_q;
  assign busy_o  = req_q ^ ack_b;
  assign hold_o  = hold_q;

  // R7: the top must never push a write into a busy channel
  a_r7_no_wr_when_busy: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    wr_i |-> !busy_o);
  // R6: an accepted write raises busy
  a_r6_busy_after_wr: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    wr_i |=> busy_o);
endmodule

// File: rtl/scm_core.sv
// Slow-domain counter, prescaler and compare.
module scm_core #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned TRIM_W = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              trim_ld_i,
  input  logic [TRIM_W-1:0] trim_i,
  input  logic              load_ld_i,
  input  logic [CNT_W-1:0]  load_i,
  input  logic              match_ld_i,
  input  logic [CNT_W-1:0]  match_i,
  output logic [CNT_W-1:0]  snap_o,
  output logic              edge_tgl_o,
  output logic              hit_tgl_o
);
  logic              en_s;
  logic [TRIM_W-1:0] trim_q, trim_d, pre_q, pre_d;
  logic [CNT_W-1:0]  count_q, count_d, match_q, match_d;
  logic              eq_q, eq_d, hit_q, edge_q;

  scm_bit_sync #(.STAGES(STAGES)) u_en_sync (
    .clk_i(sclk_i), .rst_ni(rst_ni), .d_i(en_i), .q_o(en_s)
  );

  always_comb begin
    pre_d   = pre_q;
    count_d = count_q;
    if (load_ld_i) begin
      count_d = load_i;
      pre_d   = '0;
    end else if (en_s) begin
      if (pre_q >= trim_q) begin
        pre_d   = '0;
        count_d = count_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
    trim_d  = trim_ld_i  ? trim_i  : trim_q;
    match_d = match_ld_i ? match_i : match_q;
    eq_d    = (count_d == match_d);
  end

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      count_q <= '0;
      trim_q  <= '0;
      match_q <= '0;
      eq_q    <= 1'b1;
      hit_q   <= 1'b0;
      edge_q  <= 1'b0;
    end else begin
      pre_q   <= pre_d;
      count_q <= count_d;
      trim_q  <= trim_d;
      match_q <= match_d;
      eq_q    <= eq_d;
      edge_q  <= ~edge_q;
      if (eq_d && !eq_q) hit_q <= ~hit_q;
    end
  end

  assign snap_o     = count_q;
  assign edge_tgl_o = edge_q;
  assign hit_tgl_o  = hit_q;

  // R3: disabled and no load means the count holds
  a_r3_hold_when_off: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (!en_s && !load_ld_i) |=> $stable(count_q));
  // R9: a hit event only accompanies a count equal to the match value
  a_r9_hit_at_match: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    !$stable(hit_q) |-> (count_q == match_q));
endmodule

// File: rtl/slow_cnt_match.sv
module slow_cnt_match
  import scm_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned TRIM_W = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              slow_clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = CNT_W - TRIM_W;

  logic wr, ctrl_wr, trim_sel, load_sel, match_sel;
  logic trim_ok, load_ok, match_ok, blocked;
  logic trim_busy, load_busy, match_busy;
  logic trim_ap, load_ap, match_ap;
  logic [TRIM_W-1:0] trim_hold;
  logic [CNT_W-1:0]  load_hold, match_hold, snap;
  logic edge_tgl, hit_tgl, edge_b, edge_d1, hit_b, hit_d1, edge_new, hit_new;
  logic en_q, seen_q, err_q, irq_q;
  logic [CNT_W-1:0] rd_q;

  assign wr        = bus_valid_i && bus_we_i;
  assign ctrl_wr   = wr && (bus_addr_i == A_CTRL);
  assign trim_sel  = wr && (bus_addr_i == A_TRIM);
  assign load_sel  = wr && (bus_addr_i == A_LOAD);
  assign match_sel = wr && (bus_addr_i == A_MATCH);
  assign trim_ok   = trim_sel  && !trim_busy;
  assign load_ok   = load_sel  && !load_busy;
  assign match_ok  = match_sel && !match_busy;
  assign blocked   = (trim_sel && trim_busy) || (load_sel && load_busy) ||
                     (match_sel && match_busy);

  scm_wr_chan #(.W(TRIM_W), .STAGES(STAGES)) u_trim_chan (
    .bclk_i(clk_i), .sclk_i(slow_clk_i), .rst_ni(rst_ni),
    .wr_i(trim_ok), .wdata_i(bus_wdata_i[TRIM_W-1:0]),
    .busy_o(trim_busy), .hold_o(trim_hold), .apply_o(trim_ap)
  );

  scm_wr_chan #(.W(CNT_W), .STAGES(STAGES)) u_load_chan (
    .bclk_i(clk_i), .sclk_i(slow_clk_i), .rst_ni(rst_ni),
    .wr_i(load_ok), .wdata_i(bus_wdata_i),
    .busy_o(load_busy), .hold_o(load_hold), .apply_o(load_ap)
  );

  scm_wr_chan #(.W(CNT_W), .STAGES(STAGES)) u_match_chan (
    .bclk_i(clk_i), .sclk_i(slow_clk_i), .rst_ni(rst_ni),
    .wr_i(match_ok), .wdata_i(bus_wdata_i),
    .busy_o(match_busy), .hold_o(match_hold), .apply_o(match_ap)
  );

  scm_core #(.CNT_W(CNT_W), .TRIM_W(TRIM_W), .STAGES(STAGES)) u_core (
    .sclk_i(slow_clk_i), .rst_ni(rst_ni), .en_i(en_q),
    .trim_ld_i(trim_ap), .trim_i(trim_hold),
    .load_ld_i(load_ap), .load_i(load_hold),
    .match_ld_i(match_ap), .match_i(match_hold),
    .snap_o(snap), .edge_tgl_o(edge_tgl), .hit_tgl_o(hit_tgl)
  );

  scm_bit_sync #(.STAGES(STAGES)) u_edge_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(edge_tgl), .q_o(edge_b)
  );
  scm_bit_sync #(.STAGES(STAGES)) u_hit_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hit_tgl), .q_o(hit_b)
  );

  assign edge_new = edge_b ^ edge_d1;
  assign hit_new  = hit_b ^ hit_d1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_d1 <= 1'b0;
      hit_d1  <= 1'b0;
      en_q    <= 1'b0;
      seen_q  <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      rd_q    <= '0;
    end else begin
      edge_d1 <= edge_b;
      hit_d1  <= hit_b;
      if (ctrl_wr) en_q <= bus_wdata_i[B_EN];
      // snapshot is stable for the rest of the slow period once its edge toggle arrives
      if (edge_new) begin
        seen_q <= 1'b1;
        rd_q   <= snap;
      end
      if (blocked)                         err_q <= 1'b1;
      else if (ctrl_wr && bus_wdata_i[B_ERR]) err_q <= 1'b0;
      // a new hit wins over a same-cycle clear so no event is lost
      if (hit_new)                                          irq_q <= 1'b1;
      else if ((ctrl_wr && bus_wdata_i[B_IRQ_CLR]) || match_ok) irq_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_CTRL: begin
        bus_rdata_o[B_EN]        = en_q;
        bus_rdata_o[B_SEEN]      = seen_q;
        bus_rdata_o[B_TRIM_BUSY] = trim_busy;
        bus_rdata_o[B_LOAD_BUSY] = load_busy;
        bus_rdata_o[B_MTCH_BUSY] = match_busy;
        bus_rdata_o[B_ERR]       = err_q;
        bus_rdata_o[B_IRQ]       = irq_q;
      end
      A_TRIM:  bus_rdata_o = {{PAD_W{1'b0}}, trim_hold};
      A_LOAD:  bus_rdata_o = load_hold;
      A_COUNT: bus_rdata_o = rd_q;
      A_MATCH: bus_rdata_o = match_hold;
      default: bus_rdata_o = '0;
    endcase
  end

  assign irq_o = irq_q;

  a_r2_seen_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |=> seen_q);
  a_r7_err_on_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked |=> err_q);
  a_r10_clr_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && bus_wdata_i[B_IRQ_CLR] && !hit_new) |=> !irq_o);
  a_r10_match_wr_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_ok && !hit_new) |=> !irq_o);
endmodule

// File: tb/slow_cnt_match_tb_top.sv
`timescale 1ns/1ps
module slow_cnt_match_tb_top;
  logic clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, errors = 0;
  logic [31:0] v, c0;

  always #4 clk = ~clk;

  slow_cnt_match dut_i (
    .clk_i(clk), .slow_clk_i(slow_clk), .rst_ni(rst_n),
    .bus_valid_i(valid), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  localparam int NV = 5;
  localparam logic [15:0] VT[NV] = '{16'd0, 16'd3, 16'd1, 16'd4, 16'd0};
  localparam logic [31:0] VL[NV] = '{32'd100, 32'd1000, 32'hFFFF_FFFE, 32'd50, 32'hFFFF_FFFF};
  localparam int          VK[NV] = '{7, 10, 6, 14, 1};
  localparam logic [31:0] VE[NV] = '{32'd107, 32'd1002, 32'd1, 32'd52, 32'd0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); valid = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); valid = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2 slow_clk = 1'b1;
      repeat (5) @(negedge clk);
      #2 slow_clk = 1'b0;
      repeat (5) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 32'd0);
    rd(3'd1, v); chk("R1 trim", v, 32'd0);
    rd(3'd3, v); chk("R1 count", v, 32'd0);
    rd(3'd4, v); chk("R1 match", v, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 clock seen, sticky while slow clock stops
    tick(1);
    rd(3'd0, v); chk("R2 seen", {31'd0, v[1]}, 32'd1);
    repeat (60) @(negedge clk);
    rd(3'd0, v); chk("R2 sticky", {31'd0, v[1]}, 32'd1);

    wr(3'd0, 32'h1); tick(3);

    // R5 load busy and third-edge apply
    wr(3'd2, 32'd77);
    rd(3'd0, v); chk("R5 busy set", {31'd0, v[3]}, 32'd1);
    tick(2);
    rd(3'd0, v); chk("R5 busy held", {31'd0, v[3]}, 32'd1);
    tick(1);
    rd(3'd0, v); chk("R5 busy clear", {31'd0, v[3]}, 32'd0);
    rd(3'd3, v); chk("R5 loaded", v, 32'd77);

    // R6 trim and match busy
    wr(3'd1, 32'd2);
    rd(3'd0, v); chk("R6 trim busy", {31'd0, v[2]}, 32'd1);
    tick(2);
    rd(3'd0, v); chk("R6 trim held", {31'd0, v[2]}, 32'd1);
    tick(1);
    rd(3'd0, v); chk("R6 trim clear", {31'd0, v[2]}, 32'd0);
    wr(3'd4, 32'hFFFF_0000);
    rd(3'd0, v); chk("R6 match busy", {31'd0, v[4]}, 32'd1);
    tick(3);
    rd(3'd0, v); chk("R6 match clear", {31'd0, v[4]}, 32'd0);

    // R4 / R8 prescale and wrap vectors
    for (int i = 0; i < NV; i++) begin
      wr(3'd1, {16'd0, VT[i]}); tick(3);
      wr(3'd2, VL[i]); tick(3);
      tick(VK[i]);
      rd(3'd3, v);
      chk((VL[i][31:28] == 4'hF) ? "R8 wrap" : "R4 prescale", v, VE[i]);
    end

    // R3 enable gating
    wr(3'd0, 32'h0); tick(3);
    rd(3'd3, c0); tick(5);
    rd(3'd3, v); chk("R3 hold", v, c0);
    wr(3'd0, 32'h1); tick(3);
    rd(3'd3, c0); tick(4);
    rd(3'd3, v); chk("R3 run", v, c0 + 32'd4);

    // R7 write while busy is dropped and flagged
    @(negedge clk); valid = 1'b1; we = 1'b1; addr = 3'd1; wdata = 32'd5;
    @(negedge clk); wdata = 32'd9;
    @(negedge clk); valid = 1'b0; we = 1'b0;
    rd(3'd0, v); chk("R7 err set", {31'd0, v[5]}, 32'd1);
    tick(3);
    rd(3'd1, v); chk("R7 dropped", v, 32'd5);
    wr(3'd0, 32'h21);
    rd(3'd0, v); chk("R7 err clear", {31'd0, v[5]}, 32'd0);
    wr(3'd1, 32'd0); tick(3);

    // R9 / R11 nine-tick lead
    wr(3'd0, 32'h81);
    chk("R10 ctrl clear", {31'd0, irq}, 32'd0);
    wr(3'd2, 32'd500); tick(3);
    wr(3'd4, 32'd509);
    tick(8);
    chk("R11 not early", {31'd0, irq}, 32'd0);
    rd(3'd3, v); chk("R11 count 508", v, 32'd508);
    tick(1);
    chk("R11 on ninth", {31'd0, irq}, 32'd1);
    rd(3'd3, v); chk("R9 count", v, 32'd509);
    rd(3'd0, v); chk("R9 status", {31'd0, v[6]}, 32'd1);

    // R10 clears
    wr(3'd4, 32'd600);
    chk("R10 match wr clear", {31'd0, irq}, 32'd0);
    tick(3 + 88);
    chk("R9 second hit", {31'd0, irq}, 32'd1);
    wr(3'd0, 32'h81);
    chk("R10 bit7 clear", {31'd0, irq}, 32'd0);
    rd(3'd0, v); chk("R10 status", {31'd0, v[6]}, 32'd0);

    // R12 readback latency
    @(negedge clk); #2 slow_clk = 1'b1;
    repeat (4) @(negedge clk);
    addr = 3'd3; #1; chk("R12 latency", rdata, 32'd601);
    #1 slow_clk = 1'b0;
    repeat (5) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule